// File: doc/BRIEF.md
# Processor Status Word and Condition Unit

This block keeps the processor's status word and answers, for a 3-bit condition field, whether a conditional instruction should execute. The low byte of the word holds four arithmetic flags and four control bits. The bits above it are a free field that software writes when it raises a trap, so that supervisor code can see which service was requested. The block also tracks the privilege mode. User mode is simply the state with the interrupt-enable bit set, so any event that clears that bit returns control to the supervisor.

The surrounding pipeline drives a retire pulse for every instruction that completes. With that pulse it indicates whether the instruction is a status-word write, whether it updates the flags, and whether it is a break instruction. An interrupt request takes effect only in user mode. Single-step and break-enable control bits change how the block leaves user mode and how it reacts to a break instruction. The block presents a sticky halt request for an external debugger. Waiting for an interrupt and a full halt are reported as separate outputs.

Top module: `status_word_unit`

## Requirements
- R1: After reset the whole status word is zero: supervisor mode, all flags and control bits clear, trap field zero. The debugger halt output is low.
- R2: The bits above bit 7 change only on a retiring status-word write, and then take exactly the written value, in either mode.
- R3: Flags sit at bit 0 Z, bit 1 C, bit 2 N and bit 3 V, and the flag input uses the same order. They load from the flag input only on a retire with the set-flags enable. A status-word write retiring in the same cycle wins over the flag input. A break instruction and a set-flags enable without a retire leave the flags unchanged.
- R4: For condition codes 0 to 7, the condition output is: 0 always true, 1 Z set, 2 Z clear, 3 N clear, 4 N and Z both clear, 5 N set, 6 C set, 7 V set.
- R5: The mode output follows bit 5 (interrupt enable): 1 means user mode. An interrupt request while bit 5 is set clears bit 5 and bit 4 (sleep) at the next clock. An interrupt request in supervisor mode has no effect.
- R6: A user-mode status-word write that leaves bit 5 clear enters supervisor mode at the next clock, with the written trap field visible.
- R7: Bit 7 (break enable) and bit 6 (single step) can be written only in supervisor mode. A user-mode write keeps their previous values.
- R8: With bit 6 set in user mode, the first retiring instruction returns to supervisor mode and clears bit 6. Any return from user mode to supervisor mode clears bit 6, except a break as in R9. In supervisor mode, bit 6 does not cause a mode change.
- R9: A retiring break instruction with bit 7 set raises the debugger halt output at the next clock and leaves the word unchanged; the halt output stays high until reset. With bit 7 clear, the break sets bit 6, clears bit 5, and leaves the flags unchanged.
- R10: The wait output is high when bits 4 and 5 are both set. The halt output is high when bit 4 is set and bit 5 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | An instruction completes this cycle |
| alu_setf_i | input | 1 | Retiring instruction updates the flags |
| alu_flags_i | input | 4 | New flags: Z, C, N, V from bit 0 upward |
| wr_en_i | input | 1 | Retiring instruction writes the status word |
| wr_data_i | input | WORD_W | Value written to the status word |
| brk_i | input | 1 | Retiring instruction is a break |
| irq_i | input | 1 | Interrupt request |
| cond_i | input | 3 | Condition field to evaluate |
| cond_true_o | output | 1 | Condition holds for the current flags |
| word_o | output | WORD_W | Full status word |
| flags_o | output | 4 | Z, C, N, V |
| sleep_o | output | 1 | Sleep bit |
| user_mode_o | output | 1 | 1 in user mode, 0 in supervisor mode |
| step_o | output | 1 | Single-step bit |
| brk_en_o | output | 1 | Break-enable bit |
| trap_id_o | output | WORD_W-8 | Trap field, bits above bit 7 |
| wait_o | output | 1 | Waiting for an interrupt |
| halt_o | output | 1 | Halted with interrupts disabled |
| dbg_halt_o | output | 1 | Sticky halt request for a debugger |

## Verification
The bench builds the block with the default 32-bit word, so the trap field is 24 bits wide. Random write data therefore puts varied values into the upper field and into every control-bit combination. A directed pass drives each mode change in turn: a stepped return, a trap, an interrupt that wakes the core from sleep, and a break with break enable both clear and set. A long random phase then mixes retire, write, flag, break and interrupt events. In this phase, writes and interrupts land in the same cycle and in both modes, which reaches the priority corners between them.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int unsigned B_Z     = 0;
  localparam int unsigned B_C     = 1;
  localparam int unsigned B_N     = 2;
  localparam int unsigned B_V     = 3;
  localparam int unsigned B_SLEEP = 4;
  localparam int unsigned B_GIE   = 5;
  localparam int unsigned B_STEP  = 6;
  localparam int unsigned B_BRKEN = 7;
  localparam int unsigned CTL_W   = 8;
  localparam int unsigned FLAG_W  = 4;
  localparam int unsigned CODE_W  = 3;

  typedef enum logic [CODE_W-1:0] {
    CND_ALWAYS = 3'd0,
    CND_ZERO   = 3'd1,
    CND_NZERO  = 3'd2,
    CND_GE     = 3'd3,
    CND_GT     = 3'd4,
    CND_LT     = 3'd5,
    CND_CARRY  = 3'd6,
    CND_OVF    = 3'd7
  } cond_e;

  function automatic logic cond_holds(input logic [FLAG_W-1:0] fl,
                                      input logic [CODE_W-1:0] code);
    logic r;
    case (cond_e'(code))
      CND_ALWAYS: r = 1'b1;
      CND_ZERO:   r = fl[B_Z];
      CND_NZERO:  r = ~fl[B_Z];
      CND_GE:     r = ~fl[B_N];
      CND_GT:     r = ~fl[B_N] & ~fl[B_Z];
      CND_LT:     r = fl[B_N];
      CND_CARRY:  r = fl[B_C];
      default:    r = fl[B_V];
    endcase
    return r;
  endfunction
endpackage

// File: rtl/psw_cond.sv
module psw_cond
  import psw_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              true_o
);
  always_comb true_o = cond_holds(flags_i, code_i);

  // R4: code 0 never blocks an instruction
  always_comb begin
    if (code_i == 3'd0) begin
      a_r4_always_true: assert (true_o);
    end
  end
endmodule

// File: rtl/psw_next.sv
module psw_next
  import psw_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic [WORD_W-1:0] cur_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [FLAG_W-1:0] alu_flags_i,
  input  logic              ev_brk_i,
  input  logic              ev_wr_i,
  input  logic              ev_flag_i,
  input  logic              ev_step_exit_i,
  input  logic              ev_irq_i,
  output logic [WORD_W-1:0] nxt_o,
  output logic              set_dbg_o,
  output logic              brk_step_o
);
  logic in_user;
  assign in_user    = cur_i[B_GIE];
  assign brk_step_o = ev_brk_i & ~cur_i[B_BRKEN];

  always_comb begin
    nxt_o     = cur_i;
    set_dbg_o = 1'b0;
    if (ev_brk_i) begin
      if (cur_i[B_BRKEN]) begin
        set_dbg_o = 1'b1;
      end else begin
        nxt_o[B_STEP] = 1'b1;
        nxt_o[B_GIE]  = 1'b0;
      end
    end else if (ev_wr_i) begin
      nxt_o = wr_data_i;
      if (in_user) begin
        nxt_o[B_STEP]  = cur_i[B_STEP];
        nxt_o[B_BRKEN] = cur_i[B_BRKEN];
      end
    end else if (ev_flag_i) begin
      nxt_o[B_V:B_Z] = alu_flags_i;
    end
    if (ev_step_exit_i) nxt_o[B_GIE] = 1'b0;
    if (ev_irq_i) begin
      nxt_o[B_GIE]   = 1'b0;
      nxt_o[B_SLEEP] = 1'b0;
    end
    if (in_user && !nxt_o[B_GIE] && !brk_step_o) nxt_o[B_STEP] = 1'b0;
  end
endmodule

// File: rtl/status_word_unit.sv
module status_word_unit
  import psw_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned TRAP_W = WORD_W - CTL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_i,
  input  logic              alu_setf_i,
  input  logic [3:0]        alu_flags_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              brk_i,
  input  logic              irq_i,
  input  logic [2:0]        cond_i,
  output logic              cond_true_o,
  output logic [WORD_W-1:0] word_o,
  output logic [3:0]        flags_o,
  output logic              sleep_o,
  output logic              user_mode_o,
  output logic              step_o,
  output logic              brk_en_o,
  output logic [TRAP_W-1:0] trap_id_o,
  output logic              wait_o,
  output logic              halt_o,
  output logic              dbg_halt_o
);
  logic [WORD_W-1:0] word_q, word_d;
  logic              dbg_q, set_dbg, brk_step;

  // named events for the assertions
  logic ev_brk, ev_wr, ev_flag, ev_step_exit, ev_irq;
  assign ev_brk       = retire_i & brk_i;
  assign ev_wr        = retire_i & wr_en_i & ~brk_i;
  assign ev_flag      = retire_i & alu_setf_i & ~wr_en_i & ~brk_i;
  assign ev_step_exit = retire_i & ~brk_i & word_q[B_GIE] & word_q[B_STEP];
  assign ev_irq       = irq_i & word_q[B_GIE];

  psw_next #(.WORD_W(WORD_W)) u_next (
    .cur_i          (word_q),
    .wr_data_i      (wr_data_i),
    .alu_flags_i    (alu_flags_i),
    .ev_brk_i       (ev_brk),
    .ev_wr_i        (ev_wr),
    .ev_flag_i      (ev_flag),
    .ev_step_exit_i (ev_step_exit),
    .ev_irq_i       (ev_irq),
    .nxt_o          (word_d),
    .set_dbg_o      (set_dbg),
    .brk_step_o     (brk_step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      dbg_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      if (set_dbg) dbg_q <= 1'b1;
    end
  end

  psw_cond u_cond (
    .flags_i (word_q[B_V:B_Z]),
    .code_i  (cond_i),
    .true_o  (cond_true_o)
  );

  assign word_o      = word_q;
  assign flags_o     = word_q[B_V:B_Z];
  assign sleep_o     = word_q[B_SLEEP];
  assign user_mode_o = word_q[B_GIE];
  assign step_o      = word_q[B_STEP];
  assign brk_en_o    = word_q[B_BRKEN];
  assign trap_id_o   = word_q[WORD_W-1:CTL_W];
  assign wait_o      = word_q[B_SLEEP] & word_q[B_GIE];
  assign halt_o      = word_q[B_SLEEP] & ~word_q[B_GIE];
  assign dbg_halt_o  = dbg_q;

  // R2: trap field moves only with a write
  a_r2_trap_field_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(retire_i && wr_en_i && !brk_i) |=> $stable(word_o[WORD_W-1:CTL_W]));

  // R5: interrupt in user mode leaves user mode and wakes
  a_r5_irq_enters_sup: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode_o && irq_i) |=> (!user_mode_o && !sleep_o));

  // R7: break enable cannot move while in user mode
  a_r7_brken_locked: assert property (@(posedge clk) disable iff (!rst_n)
    user_mode_o |=> $stable(brk_en_o));

  // R8: a stepped instruction returns to supervisor with step cleared
  a_r8_step_return: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode_o && step_o && retire_i && !brk_i) |=> (!user_mode_o && !step_o));

  // R9: break with enable set raises the debugger halt
  a_r9_dbg_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && brk_i && brk_en_o) |=> dbg_halt_o);

  // R9: debugger halt is sticky
  a_r9_dbg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_halt_o |=> dbg_halt_o);

  // R10: waiting and halted are exclusive
  a_r10_wait_halt_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wait_o, halt_o}));
endmodule

// File: tb/status_word_unit_tb.sv
module status_word_unit_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         retire_i = 0, alu_setf_i = 0, wr_en_i = 0, brk_i = 0, irq_i = 0;
  logic [3:0]   alu_flags_i = '0;
  logic [W-1:0] wr_data_i = '0;
  logic [2:0]   cond_i = '0;
  logic         cond_true_o, sleep_o, user_mode_o, step_o, brk_en_o;
  logic         wait_o, halt_o, dbg_halt_o;
  logic [W-1:0] word_o;
  logic [3:0]   flags_o;
  logic [W-9:0] trap_id_o;

  int checks = 0, failures = 0, cycles = 0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  status_word_unit #(.WORD_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .alu_setf_i(alu_setf_i),
    .alu_flags_i(alu_flags_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .brk_i(brk_i), .irq_i(irq_i), .cond_i(cond_i), .cond_true_o(cond_true_o),
    .word_o(word_o), .flags_o(flags_o), .sleep_o(sleep_o),
    .user_mode_o(user_mode_o), .step_o(step_o), .brk_en_o(brk_en_o),
    .trap_id_o(trap_id_o), .wait_o(wait_o), .halt_o(halt_o),
    .dbg_halt_o(dbg_halt_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model, written from the requirements
  logic [W-1:0] m_word;
  bit           m_dbg;

  function automatic bit m_cond(input logic [3:0] f, input int code);
    bit z = f[0], c = f[1], n = f[2], v = f[3];
    if (code == 0) return 1;
    if (code == 1) return z;
    if (code == 2) return !z;
    if (code == 3) return !n;
    if (code == 4) return !(n || z);
    if (code == 5) return n;
    if (code == 6) return c;
    return v;
  endfunction

  always @(posedge clk) begin
    logic [W-1:0] w;
    bit user, brk_sets;
    if (!rst_n) begin
      m_word = '0;
      m_dbg  = 0;
    end else begin
      w = m_word;
      user = m_word[5];
      brk_sets = retire_i && brk_i && !m_word[7];
      if (retire_i && brk_i) begin
        if (m_word[7]) m_dbg = 1;
        else begin w[6] = 1; w[5] = 0; end
      end else begin
        if (retire_i && wr_en_i) begin
          w = wr_data_i;
          if (user) w[7:6] = m_word[7:6];
        end else if (retire_i && alu_setf_i) begin
          w[3:0] = alu_flags_i;
        end
        if (retire_i && user && m_word[6]) w[5] = 0;
      end
      if (irq_i && user) begin w[5] = 0; w[4] = 0; end
      if (user && !w[5] && !brk_sets) w[6] = 0;
      m_word = w;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(flags_o == m_word[3:0], "R3 flags", flags_o, m_word[3:0]);
      chk(trap_id_o == m_word[W-1:8], "R2 trap field", trap_id_o, m_word[W-1:8]);
      chk(user_mode_o == m_word[5] && sleep_o == m_word[4], "R5 mode/sleep",
          {user_mode_o, sleep_o}, m_word[5:4]);
      chk(step_o == m_word[6], "R8 step", step_o, m_word[6]);
      chk(brk_en_o == m_word[7], "R7 break enable", brk_en_o, m_word[7]);
      chk(cond_true_o == m_cond(m_word[3:0], int'(cond_i)), "R4 condition",
          cond_true_o, m_cond(m_word[3:0], int'(cond_i)));
      chk(dbg_halt_o == m_dbg, "R9 debugger halt", dbg_halt_o, m_dbg);
      chk(wait_o == (m_word[4] && m_word[5]) && halt_o == (m_word[4] && !m_word[5]),
          "R10 wait/halt", {wait_o, halt_o}, {m_word[4] && m_word[5], m_word[4] && !m_word[5]});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic apply(input bit r, input bit sf, input logic [3:0] fl, input bit we,
                       input logic [W-1:0] wd, input bit bk, input bit iq);
    @(posedge clk); #2;
    retire_i = r; alu_setf_i = sf; alu_flags_i = fl; wr_en_i = we;
    wr_data_i = wd; brk_i = bk; irq_i = iq;
  endtask

  task automatic idle();
    apply(0, 0, 4'h0, 0, '0, 0, 0);
  endtask

  task automatic wr(input logic [W-1:0] d);
    apply(1, 0, 4'h0, 1, d, 0, 0); idle();
  endtask

  task automatic cond_sweep(input logic [7:0] exp, input string tag);
    for (int k = 0; k < 8; k++) begin
      cond_i = 3'(k); #1;
      chk(cond_true_o == exp[k], tag, cond_true_o, exp[k]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    chk(word_o == '0 && dbg_halt_o == 0 && user_mode_o == 0, "R1 reset state", word_o, 0);
    cmp_on = 1'b1;

    // R3 / R4: flag loads and condition sweeps
    apply(1, 1, 4'b0101, 0, '0, 0, 0); idle();
    chk(flags_o == 4'b0101, "R3 flag load", flags_o, 4'b0101);
    cond_sweep(8'b0010_0011, "R4 sweep Z,N set");
    apply(1, 1, 4'b1010, 0, '0, 0, 0); idle();
    cond_sweep(8'b1101_1101, "R4 sweep C,V set");
    apply(1, 1, 4'hF, 1, 32'h0000_0003, 0, 0); idle();
    chk(flags_o == 4'h3, "R3 write beats flags", flags_o, 4'h3);
    apply(0, 1, 4'hC, 0, '0, 0, 0); idle();
    chk(flags_o == 4'h3, "R3 no retire no load", flags_o, 4'h3);

    // R2 / R7 supervisor write of the whole word
    wr(32'h0000_ABC0);
    chk(word_o == 32'h0000_ABC0, "R2 supervisor write", word_o, 32'h0000_ABC0);

    // R8 stepped instruction
    wr(32'h0000_00E0);
    chk(user_mode_o == 1, "R8 entered user", user_mode_o, 1);
    apply(1, 1, 4'h1, 0, '0, 0, 0); idle();
    chk(word_o == 32'h0000_0081, "R8 step return", word_o, 32'h0000_0081);

    // R7 user write cannot touch step/break enable; R6 trap
    wr(32'h0000_0020);
    wr(32'h0000_00E0);
    chk(word_o == 32'h0000_0020, "R7 user write masked", word_o, 32'h0000_0020);
    wr(32'h0000_4200);
    chk(word_o == 32'h0000_4200 && user_mode_o == 0, "R6 trap", word_o, 32'h0000_4200);

    // R10 / R5 sleep and interrupts
    wr(32'h0000_0030);
    chk(wait_o == 1 && halt_o == 0, "R10 wait", {wait_o, halt_o}, 2'b10);
    apply(0, 0, 4'h0, 0, '0, 0, 1); idle();
    chk(word_o == 32'h0, "R5 irq wake", word_o, 0);
    apply(0, 0, 4'h0, 0, '0, 0, 1); idle();
    chk(word_o == 32'h0, "R5 irq ignored in supervisor", word_o, 0);
    wr(32'h0000_0010);
    chk(halt_o == 1 && wait_o == 0, "R10 halt", {wait_o, halt_o}, 2'b01);

    // R9 break both ways
    wr(32'h0000_0025);
    apply(1, 1, 4'h0, 0, '0, 1, 0); idle();
    chk(word_o == 32'h0000_0045 && dbg_halt_o == 0, "R9 break to supervisor", word_o, 32'h45);
    wr(32'h0000_0080);
    apply(1, 0, 4'h0, 0, '0, 1, 0); idle();
    chk(dbg_halt_o == 1 && word_o == 32'h80, "R9 break halts", {dbg_halt_o, word_o}, {1'b1, 32'h80});
    idle(); idle();
    chk(dbg_halt_o == 1, "R9 halt sticky", dbg_halt_o, 1);

    // reset again, then random traffic against the model
    @(posedge clk); #2 rst_n = 1'b0;
    @(posedge clk); #2 rst_n = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      apply(($urandom % 2) == 0, ($urandom % 2) == 0, 4'($urandom), ($urandom % 6) == 0,
            $urandom, ($urandom % 40) == 0, ($urandom % 12) == 0);
      cond_i = 3'($urandom);
    end
    idle(); idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule